// File: doc/BRIEF.md
# Page Fault Detection and Error Reporting Unit

This block sits after address translation and decides, for one memory access at a time, whether the access faults. Each request carries the virtual address, the access kind, the privilege level and a shadow-stack flag. It also carries the translation outcome: either a TLB hit with the final page-entry flags, or the result of a page walk with the flags of the entry the walk reached. The control enables for large-page/extended addressing, no-execute and control-flow enforcement come in with it, along with two results from checkers outside the block: protection key and reverse-map.

One cycle after a request is accepted, the block presents a result. A faulting access yields exception vector 14 and a 32-bit error code whose bits describe the cause, and it loads the full 64-bit faulting address into a fault-address register. An access that does not fault yields the physical address, with a translation-valid flag. Requests enter on a valid/ready handshake. Results leave on a valid/ready handshake and are held until the consumer takes them. `req_ready` is high whenever the result register is empty or is being emptied in the same cycle, so a consumer that keeps `out_ready` high gets one result per cycle. The fault pulse and the fault-address register are plain status pins and do not wait for the handshake.

Access kind encoding on `req_kind`: 0 read, 1 write, 2 instruction fetch, 3 treated as a read. Privilege level 3 is user; levels 0 to 2 are supervisor.

Top module: `pf_fault_unit`

## Requirements
- R1: The result is a fault with `out_vector` = 14 and error bit 0 clear when the final entry is absent. That is the case on a TLB hit with `pte_present` = 0, and on a TLB miss with either `walk_ok` = 0 or `pte_present` = 0.
- R2: A write (kind 1) to a present page with `pte_rw` = 0 faults with error bit 0 = 1 and bit 1 = 1. Error bit 1 is 1 for every faulting write and 0 for every faulting read or fetch.
- R3: An access at level 3 to a present page with `pte_us` = 0 faults, and error bit 2 is set on every fault taken at level 3. At levels 0 to 2, `pte_us` has no effect and bit 2 is 0.
- R4: A present entry with `pte_rsvd` = 1 faults with error bits 0 and 3 set when `en_pse` or `en_pae` is 1. When both are 0, the reserved flag is ignored and the access succeeds.
- R5: A fetch (kind 2) from a present page with `pte_nx` = 1 faults with error bit 4 set when `en_nxe` = 1, and succeeds when `en_nxe` = 0. Error bit 4 is set on every faulting fetch.
- R6: `pkey_fail` on a present page faults with error bit 5 set only for a data access (kind 0, 1 or 3) at level 3. At other levels and for fetches it has no effect.
- R7: On a fault, error bit 6 equals `req_shstk` AND `en_cet`. `rmp_fail` on a present page faults with error bit 31 set.
- R8: Error bits 7 to 30 are always 0. A result without a fault has error code 0, vector 0, `xlat_valid` = 1, and `out_paddr` = {`pte_pfn`, `req_vaddr`[11:0]}.
- R9: The result, `fault_pulse` and the fault-address update all appear in the cycle after acceptance. `fault_pulse` is high for exactly that one cycle, and only for a faulting result.
- R10: `cr2` takes the full 64-bit virtual address of each faulting access and keeps its value across non-faulting accesses. Reset clears `cr2` and every output.
- R11: While `out_valid` = 1 and `out_ready` = 0, the result holds steady and `req_ready` is 0. Otherwise `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 64 | Virtual address of the access |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_cpl | input | 2 | Privilege level, 3 is user |
| req_shstk | input | 1 | Shadow-stack access |
| tlb_hit | input | 1 | Translation came from a TLB hit |
| walk_ok | input | 1 | Page walk completed (used on a miss) |
| pte_present | input | 1 | Final entry present flag |
| pte_rw | input | 1 | Final entry writable flag |
| pte_us | input | 1 | Final entry user-accessible flag |
| pte_nx | input | 1 | Final entry no-execute flag |
| pte_rsvd | input | 1 | A reserved entry bit was found set |
| pte_pfn | input | 40 | Physical frame number |
| en_pse | input | 1 | Large-page enable |
| en_pae | input | 1 | Extended-address enable |
| en_nxe | input | 1 | No-execute enable |
| en_cet | input | 1 | Control-flow enforcement enable |
| pkey_fail | input | 1 | Protection key check failed |
| rmp_fail | input | 1 | Reverse-map check failed |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_fault | output | 1 | Result is a fault |
| out_vector | output | 8 | Exception vector, 14 on fault |
| out_errcode | output | 32 | Fault error code |
| out_paddr | output | 52 | Physical address on success |
| xlat_valid | output | 1 | Translation succeeded |
| fault_pulse | output | 1 | One-cycle fault indication |
| cr2 | output | 64 | Last faulting virtual address |

## Verification
The assertions assume that request fields stay stable while `req_valid` is high and `req_ready` is low, and that `out_ready` is driven cleanly between clock edges. The stimulus changes inputs only just after a rising edge and holds each request until it is taken. The checks on the fault-address register compare it with the address seen in the previous cycle, so they rely on a request being accepted in the same cycle that address was presented; the driver never lets a stalled request change its address. The page-entry flags are treated as consistent for the final entry whether they came from a hit or from a walk, and the bench drives only such combinations.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALTRD = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic present;
    logic rw;
    logic us;
    logic nx;
    logic rsvd;
  } pte_flags_t;

  typedef struct packed {
    logic absent;
    logic ro_write;
    logic sup_page;
    logic no_exec;
    logic rsvd_hit;
    logic key_viol;
    logic rmp_viol;
  } pf_cause_t;

  localparam int EB_P    = 0;
  localparam int EB_WR   = 1;
  localparam int EB_US   = 2;
  localparam int EB_RSV  = 3;
  localparam int EB_ID   = 4;
  localparam int EB_PK   = 5;
  localparam int EB_SS   = 6;
  localparam int EB_RMP  = 31;
  localparam logic [1:0] USER_CPL = 2'd3;
endpackage

// File: rtl/pf_cause_eval.sv
module pf_cause_eval
  import pf_pkg::*;
(
  input  logic [1:0]  kind,
  input  logic [1:0]  cpl,
  input  logic        hit,
  input  logic        walk_ok,
  input  pte_flags_t  flags,
  input  logic        en_pse,
  input  logic        en_pae,
  input  logic        en_nxe,
  input  logic        pkey_fail,
  input  logic        rmp_fail,
  output pf_cause_t   cause,
  output logic        fault
);
  logic entry_here;
  logic is_user;
  logic is_write;
  logic is_fetch;

  always_comb begin
    entry_here = hit ? flags.present : (walk_ok && flags.present);
    is_user    = (cpl == USER_CPL);
    is_write   = (kind == ACC_WRITE);
    is_fetch   = (kind == ACC_FETCH);

    cause          = '0;
    cause.absent   = !entry_here;
    if (entry_here) begin
      cause.ro_write = is_write && !flags.rw;
      cause.sup_page = is_user && !flags.us;
      cause.no_exec  = is_fetch && flags.nx && en_nxe;
      cause.rsvd_hit = flags.rsvd && (en_pse || en_pae);
      cause.key_viol = pkey_fail && is_user && !is_fetch;
      cause.rmp_viol = rmp_fail;
    end
    fault = |cause;
  end
endmodule

// File: rtl/pf_code_pack.sv
module pf_code_pack
  import pf_pkg::*;
#(
  parameter int EC_W = 32
) (
  input  pf_cause_t        cause,
  input  logic             fault,
  input  logic [1:0]       kind,
  input  logic [1:0]       cpl,
  input  logic             shstk,
  input  logic             en_cet,
  output logic [EC_W-1:0]  code
);
  logic [EC_W-1:0] raw;

  generate
    for (genvar b = 0; b < EC_W; b++) begin : g_bit
      if (b == EB_P) begin : g_p
        assign raw[b] = !cause.absent;
      end else if (b == EB_WR) begin : g_wr
        assign raw[b] = (kind == ACC_WRITE);
      end else if (b == EB_US) begin : g_us
        assign raw[b] = (cpl == USER_CPL);
      end else if (b == EB_RSV) begin : g_rsv
        assign raw[b] = cause.rsvd_hit;
      end else if (b == EB_ID) begin : g_id
        assign raw[b] = (kind == ACC_FETCH);
      end else if (b == EB_PK) begin : g_pk
        assign raw[b] = cause.key_viol;
      end else if (b == EB_SS) begin : g_ss
        assign raw[b] = shstk && en_cet;
      end else if (b == EB_RMP) begin : g_rmp
        assign raw[b] = cause.rmp_viol;
      end else begin : g_zero
        assign raw[b] = 1'b0;
      end
    end
  endgenerate

  assign code = fault ? raw : '0;
endmodule

// File: rtl/pf_report_stage.sv
module pf_report_stage #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 52,
  parameter int EC_W  = 32,
  parameter int VEC_W = 8,
  parameter int VEC_PF = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_fault,
  input  logic [EC_W-1:0]   in_code,
  input  logic [PA_W-1:0]   in_paddr,
  input  logic [VA_W-1:0]   in_vaddr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fault,
  output logic [VEC_W-1:0]  out_vector,
  output logic [EC_W-1:0]   out_errcode,
  output logic [PA_W-1:0]   out_paddr,
  output logic              xlat_valid,
  output logic              fault_pulse,
  output logic [VA_W-1:0]   cr2
);
  localparam logic [VEC_W-1:0] VEC_CODE = VEC_W'(VEC_PF);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_fault   <= 1'b0;
      out_vector  <= '0;
      out_errcode <= '0;
      out_paddr   <= '0;
      xlat_valid  <= 1'b0;
      fault_pulse <= 1'b0;
      cr2         <= '0;
    end else begin
      fault_pulse <= take && in_fault;
      if (take) begin
        out_valid   <= 1'b1;
        out_fault   <= in_fault;
        out_vector  <= in_fault ? VEC_CODE : '0;
        out_errcode <= in_code;
        out_paddr   <= in_fault ? '0 : in_paddr;
        xlat_valid  <= !in_fault;
        if (in_fault) cr2 <= in_vaddr;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
        xlat_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pf_fault_unit.sv
module pf_fault_unit
  import pf_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 52,
  parameter int PAGE_BITS = 12,
  parameter int EC_W      = 32,
  parameter int VEC_W     = 8,
  parameter int VEC_PF    = 14,
  localparam int PFN_W    = PA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_cpl,
  input  logic              req_shstk,
  input  logic              tlb_hit,
  input  logic              walk_ok,
  input  logic              pte_present,
  input  logic              pte_rw,
  input  logic              pte_us,
  input  logic              pte_nx,
  input  logic              pte_rsvd,
  input  logic [PFN_W-1:0]  pte_pfn,
  input  logic              en_pse,
  input  logic              en_pae,
  input  logic              en_nxe,
  input  logic              en_cet,
  input  logic              pkey_fail,
  input  logic              rmp_fail,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fault,
  output logic [VEC_W-1:0]  out_vector,
  output logic [EC_W-1:0]   out_errcode,
  output logic [PA_W-1:0]   out_paddr,
  output logic              xlat_valid,
  output logic              fault_pulse,
  output logic [VA_W-1:0]   cr2
);
  pte_flags_t      flags;
  pf_cause_t       cause;
  logic            fault;
  logic [EC_W-1:0] code;
  logic [PA_W-1:0] paddr;

  assign flags = '{present: pte_present, rw: pte_rw, us: pte_us,
                   nx: pte_nx, rsvd: pte_rsvd};
  assign paddr = {pte_pfn, req_vaddr[PAGE_BITS-1:0]};

  pf_cause_eval u_cause (
    .kind      (req_kind),
    .cpl       (req_cpl),
    .hit       (tlb_hit),
    .walk_ok   (walk_ok),
    .flags     (flags),
    .en_pse    (en_pse),
    .en_pae    (en_pae),
    .en_nxe    (en_nxe),
    .pkey_fail (pkey_fail),
    .rmp_fail  (rmp_fail),
    .cause     (cause),
    .fault     (fault)
  );

  pf_code_pack #(.EC_W(EC_W)) u_code (
    .cause  (cause),
    .fault  (fault),
    .kind   (req_kind),
    .cpl    (req_cpl),
    .shstk  (req_shstk),
    .en_cet (en_cet),
    .code   (code)
  );

  pf_report_stage #(
    .VA_W(VA_W), .PA_W(PA_W), .EC_W(EC_W), .VEC_W(VEC_W), .VEC_PF(VEC_PF)
  ) u_report (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (req_valid),
    .in_ready    (req_ready),
    .in_fault    (fault),
    .in_code     (code),
    .in_paddr    (paddr),
    .in_vaddr    (req_vaddr),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_fault   (out_fault),
    .out_vector  (out_vector),
    .out_errcode (out_errcode),
    .out_paddr   (out_paddr),
    .xlat_valid  (xlat_valid),
    .fault_pulse (fault_pulse),
    .cr2         (cr2)
  );
endmodule

// File: rtl/pf_fault_chk.sv
module pf_fault_chk #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 52,
  parameter int EC_W   = 32,
  parameter int VEC_W  = 8,
  parameter int VEC_PF = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_fault,
  input logic [VEC_W-1:0]  out_vector,
  input logic [EC_W-1:0]   out_errcode,
  input logic [PA_W-1:0]   out_paddr,
  input logic              xlat_valid,
  input logic              fault_pulse,
  input logic [VA_W-1:0]   cr2
);
  p_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> out_vector == VEC_W'(VEC_PF));

  p_clean_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fault |-> out_errcode == '0 && out_vector == '0 && xlat_valid);

  p_spare_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_errcode[EC_W-2:7] == '0);

  p_pulse_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> out_valid && out_fault && !xlat_valid);

  p_cr2_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> cr2 == $past(req_vaddr));

  p_cr2_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_pulse |-> $stable(cr2));

  p_stall_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && !fault_pulse
      && $stable(out_errcode) && $stable(out_paddr) && $stable(out_fault));
endmodule

bind pf_fault_unit pf_fault_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .EC_W(EC_W), .VEC_W(VEC_W), .VEC_PF(VEC_PF)
) u_chk (.*);

// File: tb/sim_pf_fault_unit.sv
module sim_pf_fault_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 64;
  localparam int PA_W = 52;
  localparam int PFN_W = 40;

  typedef struct {
    logic [63:0] va;
    logic [1:0]  kind;
    logic [1:0]  cpl;
    logic        ss, hit, walk, p, rw, us, nx, rsv;
    logic [39:0] pfn;
    logic        pse, pae, nxe, cet, pk, rmp;
    string       tag;
  } req_t;

  typedef struct {
    logic        fault;
    logic [31:0] code;
    logic [51:0] paddr;
    logic [63:0] va;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0] req_kind = '0, req_cpl = '0;
  logic req_shstk = 0, tlb_hit = 0, walk_ok = 0, pte_present = 0, pte_rw = 0;
  logic pte_us = 0, pte_nx = 0, pte_rsvd = 0;
  logic [39:0] pte_pfn = '0;
  logic en_pse = 0, en_pae = 0, en_nxe = 0, en_cet = 0, pkey_fail = 0, rmp_fail = 0;
  logic out_valid, out_ready = 1, out_fault, xlat_valid, fault_pulse;
  logic [7:0] out_vector;
  logic [31:0] out_errcode;
  logic [51:0] out_paddr;
  logic [63:0] cr2;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic [63:0] exp_cr2 = '0;
  logic prev_hold = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_fault_unit u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input req_t r);
    exp_t e;
    logic here, usr, wr, fe, rf, pm, kf;
    here = r.hit ? r.p : (r.walk & r.p);
    usr = (r.cpl == 2'd3);
    wr = (r.kind == 2'd1);
    fe = (r.kind == 2'd2);
    rf = here & r.rsv & (r.pse | r.pae);
    pm = here & ((wr & !r.rw) | (usr & !r.us) | (fe & r.nx & r.nxe));
    kf = here & r.pk & usr & !fe;
    e.fault = !here | rf | pm | kf | (here & r.rmp);
    e.code = '0;
    if (e.fault) begin
      e.code[0] = here;
      e.code[1] = wr;
      e.code[2] = usr;
      e.code[3] = rf;
      e.code[4] = fe;
      e.code[5] = kf;
      e.code[6] = r.ss & r.cet;
      e.code[31] = here & r.rmp;
    end
    e.paddr = e.fault ? '0 : {r.pfn, r.va[11:0]};
    e.va = r.va;
    e.tag = r.tag;
    return e;
  endfunction

  task automatic send(input req_t r);
    logic ok;
    req_vaddr = r.va; req_kind = r.kind; req_cpl = r.cpl; req_shstk = r.ss;
    tlb_hit = r.hit; walk_ok = r.walk; pte_present = r.p; pte_rw = r.rw;
    pte_us = r.us; pte_nx = r.nx; pte_rsvd = r.rsv; pte_pfn = r.pfn;
    en_pse = r.pse; en_pae = r.pae; en_nxe = r.nxe; en_cet = r.cet;
    pkey_fail = r.pk; rmp_fail = r.rmp;
    req_valid = 1;
    do begin
      @(negedge clk);
      ok = req_ready;
      if (ok) q.push_back(model(r));
      @(posedge clk);
      #1;
    end while (!ok);
    req_valid = 0;
  endtask

  function automatic req_t base(input logic [63:0] va, input string tag);
    req_t r;
    r.va = va; r.kind = 2'd0; r.cpl = 2'd0; r.ss = 0; r.hit = 1; r.walk = 1;
    r.p = 1; r.rw = 1; r.us = 1; r.nx = 0; r.rsv = 0; r.pfn = 40'h12345_6789;
    r.pse = 0; r.pae = 0; r.nxe = 0; r.cet = 0; r.pk = 0; r.rmp = 0; r.tag = tag;
    return r;
  endfunction

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (q.size() == 0) begin
          chk("R9 unexpected result", 64'(out_valid), 64'd0);
        end else begin
          exp_t e;
          e = q[0];
          chk({e.tag, " fault"}, 64'(out_fault), 64'(e.fault));
          chk({e.tag, " errcode"}, 64'(out_errcode), 64'(e.code));
          chk({e.tag, " R1 vector"}, 64'(out_vector), e.fault ? 64'd14 : 64'd0);
          chk({e.tag, " R8 paddr"}, 64'(out_paddr), 64'(e.paddr));
          chk({e.tag, " R8 xlat_valid"}, 64'(xlat_valid), 64'(!e.fault));
          if (!prev_hold) begin
            if (e.fault) exp_cr2 = e.va;
            chk({e.tag, " R9 pulse"}, 64'(fault_pulse), 64'(e.fault));
          end else begin
            chk({e.tag, " R9 pulse single"}, 64'(fault_pulse), 64'd0);
          end
          chk({e.tag, " R10 cr2"}, cr2, exp_cr2);
          if (!out_ready) chk("R11 ready low in stall", 64'(req_ready), 64'd0);
          if (out_ready) void'(q.pop_front());
        end
      end
      prev_hold = out_valid && !out_ready;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req_t r;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset cr2", cr2, 64'd0);
    chk("R10 reset out_valid", 64'(out_valid), 64'd0);
    chk("R10 reset pulse", 64'(fault_pulse), 64'd0);
    chk("R10 reset xlat", 64'(xlat_valid), 64'd0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R11 ready idle", 64'(req_ready), 64'd1);

    r = base(64'hFFFF_8000_0000_1ABC, "R8 plain read"); send(r);
    r = base(64'h0000_7FFF_0000_2000, "R1 hit not present"); r.p = 0; r.kind = 2'd1; send(r);
    r = base(64'h0000_0000_0040_3000, "R1 walk failed"); r.hit = 0; r.walk = 0; r.cpl = 2'd3; send(r);
    r = base(64'h0000_0000_0040_4000, "R8 walk ok"); r.hit = 0; send(r);
    r = base(64'hDEAD_BEEF_0000_5123, "R2 write ro"); r.kind = 2'd1; r.rw = 0; send(r);
    r = base(64'h0000_0000_1111_6000, "R3 user sup page"); r.cpl = 2'd3; r.us = 0; send(r);
    r = base(64'h0000_0000_1111_7000, "R3 sup on sup page"); r.cpl = 2'd2; r.us = 0; send(r);
    r = base(64'h0000_0000_2222_8000, "R4 rsvd pae"); r.rsv = 1; r.pae = 1; send(r);
    r = base(64'h0000_0000_2222_9000, "R4 rsvd pse"); r.rsv = 1; r.pse = 1; r.cpl = 2'd3; send(r);
    r = base(64'h0000_0000_2222_A000, "R4 rsvd ignored"); r.rsv = 1; send(r);
    r = base(64'h0000_0000_3333_B000, "R5 fetch nx"); r.kind = 2'd2; r.nx = 1; r.nxe = 1; send(r);
    r = base(64'h0000_0000_3333_C000, "R5 nx disabled"); r.kind = 2'd2; r.nx = 1; send(r);
    r = base(64'h0000_0000_4444_D000, "R6 pkey user"); r.cpl = 2'd3; r.pk = 1; send(r);
    r = base(64'h0000_0000_4444_E000, "R6 pkey sup"); r.pk = 1; send(r);
    r = base(64'h0000_0000_4444_F000, "R6 pkey fetch"); r.pk = 1; r.cpl = 2'd3; r.kind = 2'd2; send(r);
    r = base(64'h0000_0000_5555_0000, "R7 shstk cet"); r.p = 0; r.ss = 1; r.cet = 1; r.kind = 2'd1; send(r);
    r = base(64'h0000_0000_5555_1000, "R7 shstk nocet"); r.p = 0; r.ss = 1; send(r);
    r = base(64'h0000_0000_5555_2000, "R7 rmp"); r.rmp = 1; r.kind = 2'd3; send(r);

    // R11 back-pressure
    @(posedge clk); #1;
    out_ready = 0;
    r = base(64'h0000_0000_6666_3000, "R11 stalled fault"); r.rw = 0; r.kind = 2'd1; send(r);
    fork
      begin
        req_t r2;
        r2 = base(64'h0000_0000_6666_4ABC, "R11 queued ok");
        send(r2);
      end
      begin
        repeat (4) @(posedge clk);
        #1;
        out_ready = 1;
      end
    join

    repeat (6) @(posedge clk);
    chk("R9 all results seen", 64'(q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule